// File: doc/BRIEF.md
# Pipelined Byte-Write Control

This block sits between the control pins of a synchronous pipelined SRAM and its storage array. Each rising clock edge captures the global-write, byte-write-enable and per-lane write strobes together with three chip selects. In the following cycle, the captured values drive a per-lane write-enable vector to the array. The internal write needs no further external timing.

A selected cycle that enables no lane is a read. Read data leaves through an output register, so the output drivers of the shared data bus turn on in the second cycle after the read is sampled. The drive enable is itself registered, so a deselect takes effect one pipeline cycle after it is sampled. Drive is also gated by an asynchronous output enable, and it is forced off while a write is in progress. The number of byte lanes is a parameter: 2, 4 or 8 lanes, for data widths of 18, 36 or 72 bits.

Top module: `bw_ctrl_top`

## Requirements
- R1: While rst_ni is low, and after its release until inputs are sampled, wr_lane_o is all zeros and drive_en_o is low.
- R2: When the device is selected and gw_ni is low at a rising edge, every bit of wr_lane_o is 1 in the cycle after that edge, whatever bwe_ni and bw_ni are.
- R3: When selected with gw_ni high and bwe_ni low, bit i of wr_lane_o is 1 in the next cycle exactly when bw_ni[i] was low (bit i of bw_ni maps to bit i of wr_lane_o).
- R4: When selected with gw_ni high and either bwe_ni high or all of bw_ni high, wr_lane_o is all zeros in the next cycle and the cycle is a read.
- R5: The device is selected only when cs_a_ni, cs_b_ni and cs_c_ni are all low. If any of them is high, neither a write nor a read results.
- R6: A read sampled at edge k makes drive_en_o high between edge k+1 and edge k+2, provided oe_ni is low and no write is active then.
- R7: Single-cycle deselect: a deselect sampled at edge k makes drive_en_o low after edge k+1.
- R8: drive_en_o is low whenever oe_ni is high, with no clock delay.
- R9: drive_en_o is low in any cycle where wr_lane_o has a bit set.
- R10: LANES must be 2, 4 or 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_a_ni | input | 1 | Chip select A, active low |
| cs_b_ni | input | 1 | Chip select B, active low |
| cs_c_ni | input | 1 | Chip select C, active low |
| gw_ni | input | 1 | Global write, all lanes, active low |
| bwe_ni | input | 1 | Byte-write master enable, active low |
| bw_ni | input | LANES | Per-lane write strobes, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wr_lane_o | output | LANES | Per-lane write enable to the array, active high |
| drive_en_o | output | 1 | Output-driver enable for the data bus |

## Verification
The port assertions compare wr_lane_o with the pin values of the previous edge. They therefore assume that every control input is driven to a known 0 or 1 from the first edge after reset. The bench drives all inputs on the falling edge from time zero, so no X ever reaches an edge. The drive assertions expect oe_ni to be a clean level. The bench changes oe_ni only between edges and keeps it low in every vector except the one that tests it.

// File: rtl/bw_ctrl_pkg.sv
package bw_ctrl_pkg;
  typedef struct packed {
    logic sel;
    logic gw;
    logic bwe;
  } ctrl_t;
endpackage

// File: rtl/bw_ctrl_reg.sv
module bw_ctrl_reg
  import bw_ctrl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cs_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output ctrl_t            ctrl_q_o,
  output logic [LANES-1:0] bw_q_o
);
  ctrl_t            ctrl_q;
  logic [LANES-1:0] bw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      bw_q   <= '0;
    end else begin
      ctrl_q.sel <= ~|cs_ni;
      ctrl_q.gw  <= ~gw_ni;
      ctrl_q.bwe <= ~bwe_ni;
      bw_q       <= ~bw_ni;
    end
  end

  assign ctrl_q_o = ctrl_q;
  assign bw_q_o   = bw_q;
endmodule

// File: rtl/bw_lane_dec.sv
module bw_lane_dec
  import bw_ctrl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  ctrl_t            ctrl_i,
  input  logic [LANES-1:0] bw_i,
  output logic [LANES-1:0] wr_lane_o,
  output logic             rd_req_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // global write wins over per-lane strobes
    assign wr_lane_o[i] = ctrl_i.sel & (ctrl_i.gw | (ctrl_i.bwe & bw_i[i]));
  end

  assign rd_req_o = ctrl_i.sel & ~|wr_lane_o;
endmodule

// File: rtl/bw_oe_pipe.sv
module bw_oe_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic wr_any_i,
  input  logic oe_ni,
  output logic drive_en_o
);
  logic rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_req_i;
  end

  assign drive_en_o = rd_q & ~oe_ni & ~wr_any_i;

  AST_DRIVE_NEEDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |-> $past(rd_req_i)); // R6
  AST_DESEL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !drive_en_o); // R7
  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_en_o); // R8
  AST_WR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any_i |-> !drive_en_o); // R9
endmodule

// File: rtl/bw_ctrl_top.sv
module bw_ctrl_top
  import bw_ctrl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_a_ni,
  input  logic             cs_b_ni,
  input  logic             cs_c_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             oe_ni,
  output logic [LANES-1:0] wr_lane_o,
  output logic             drive_en_o
);
  localparam logic [LANES-1:0] ALL_LANES = '1;

  ctrl_t            ctrl_q;
  logic [LANES-1:0] bw_q;
  logic             rd_req;
  logic             cs_ok;

  initial assert (LANES == 2 || LANES == 4 || LANES == 8); // R10

  bw_ctrl_reg #(.LANES(LANES)) i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   ({cs_c_ni, cs_b_ni, cs_a_ni}),
    .gw_ni   (gw_ni),
    .bwe_ni  (bwe_ni),
    .bw_ni   (bw_ni),
    .ctrl_q_o(ctrl_q),
    .bw_q_o  (bw_q)
  );

  bw_lane_dec #(.LANES(LANES)) i_dec (
    .ctrl_i   (ctrl_q),
    .bw_i     (bw_q),
    .wr_lane_o(wr_lane_o),
    .rd_req_o (rd_req)
  );

  bw_oe_pipe i_oe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_req_i  (rd_req),
    .wr_any_i  (|wr_lane_o),
    .oe_ni     (oe_ni),
    .drive_en_o(drive_en_o)
  );

  assign cs_ok = !cs_a_ni && !cs_b_ni && !cs_c_ni;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (wr_lane_o == '0 && !drive_en_o)); // R1
  AST_GW_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ok && !gw_ni) |=> wr_lane_o == ALL_LANES); // R2
  AST_BYTE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ok && gw_ni && !bwe_ni) |=> wr_lane_o == ~$past(bw_ni)); // R3
  AST_NO_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && bwe_ni) |=> wr_lane_o == '0); // R4
  AST_DESEL_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ok |=> wr_lane_o == '0); // R5
endmodule

// File: tb/test_bw_ctrl_top.sv
module test_bw_ctrl_top;
  localparam int LANES = 4;
  localparam int NV = 10;
  // [12:10] cs a,b,c  [9] gw_n  [8] bwe_n  [7:4] bw_n  [3:0] expected wr_lane
  localparam logic [12:0] VEC [NV] = '{
    13'b000_0_1_1111_1111,
    13'b000_0_0_1010_1111,
    13'b000_1_0_1010_0101,
    13'b000_1_0_0000_1111,
    13'b000_1_1_0000_0000,
    13'b000_1_0_1111_0000,
    13'b100_0_0_0000_0000,
    13'b010_0_1_0000_0000,
    13'b001_1_0_0000_0000,
    13'b000_1_0_1110_0001
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c_n = 1'b1;
  logic             gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [LANES-1:0] bw_n = '1;
  logic [LANES-1:0] wr_lane;
  logic             drive_en;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bw_ctrl_top #(.LANES(LANES)) i_bw_ctrl_top (
    .clk_i(clk), .rst_ni(rst_n),
    .cs_a_ni(cs_a_n), .cs_b_ni(cs_b_n), .cs_c_ni(cs_c_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n),
    .wr_lane_o(wr_lane), .drive_en_o(drive_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 2 ns after the next rising edge
  task automatic step(input logic [2:0] cs, input logic g, input logic b,
                      input logic [LANES-1:0] s);
    @(negedge clk);
    {cs_a_n, cs_b_n, cs_c_n} = cs;
    gw_n = g; bwe_n = b; bw_n = s;
    @(posedge clk);
    #2;
  endtask

  task automatic rd();    step(3'b000, 1'b1, 1'b1, '1); endtask
  task automatic desel(); step(3'b111, 1'b1, 1'b1, '1); endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset wr_lane", 32'(wr_lane), 0);
    chk("R1 reset drive", 32'(drive_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after release", 32'(drive_en), 0);

    for (int i = 0; i < NV; i++) begin
      string req;
      step(VEC[i][12:10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      if (VEC[i][12:10] != 3'b000) req = "R5";
      else if (!VEC[i][9])         req = "R2";
      else if (!VEC[i][8] && VEC[i][3:0] != 0) req = "R3";
      else                          req = "R4";
      chk(req, 32'(wr_lane), 32'(VEC[i][3:0]));
    end

    // R6 read latency and R7 single-cycle deselect
    desel(); desel();
    rd();
    chk("R6 drive not yet", 32'(drive_en), 0);
    rd();
    chk("R6 drive on", 32'(drive_en), 1);
    desel();
    chk("R7 last read still driven", 32'(drive_en), 1);
    desel();
    chk("R7 released after deselect", 32'(drive_en), 0);

    // R5 partial select yields no read
    step(3'b010, 1'b1, 1'b1, '1);
    desel();
    chk("R5 partial select no drive", 32'(drive_en), 0);

    // R8 async output enable
    rd(); rd();
    #1 oe_n = 1'b1;
    #1 chk("R8 oe high", 32'(drive_en), 0);
    oe_n = 1'b0;
    #1 chk("R8 oe low again", 32'(drive_en), 1);

    // R9 write after read forces drive off
    rd();
    step(3'b000, 1'b1, 1'b0, 4'b0111);
    chk("R9 write lane", 32'(wr_lane), 32'h8);
    chk("R9 drive off in write", 32'(drive_en), 0);
    desel();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule